// File: doc/BRIEF.md
# Banked Exception Entry Sequencer

This block holds the architectural register state of a 32-bit processor core that keeps separate copies of some registers per operating mode: sixteen current-view general registers (R15 being the program counter), the current status word, the current saved-status word, and the inactive copies of the banked registers. It performs exception entry and explicit mode changes. Every change completes in a single clock edge.

On exception entry it picks the target mode from the request code and swaps the banked stack pointer, link register and saved-status word. It also moves R8 to R12 when fast-interrupt mode is entered or left. It then saves the pre-entry status word into the new saved-status register and sets the mask bits. The link register receives the return address and the program counter receives the vector address. A plain status-word write that changes the mode field performs the same bank swap without the entry actions.

Software-visible state is reached through one register write port, one combinational read port, a status-word write port, and two status outputs. A `highVec` input selects the high vector base.

Top module: `exc_seq_top`

## Requirements
- R1: After reset the status word is 0x000001D3, which is supervisor mode 0x13 with A (bit 8), I (bit 7) and F (bit 6) set. The saved-status word and all sixteen registers read zero.
- R2: Mode field encodings are user 0x10, fast interrupt 0x11, interrupt 0x12, supervisor 0x13, abort 0x17, undefined 0x1B and system 0x1F. User and system share one copy of R13, R14 and the saved-status word. Each of the other five modes has a private copy that is preserved across mode changes.
- R3: Entering fast-interrupt mode parks the current R8 to R12 and restores the fast-interrupt copies. Leaving it does the reverse. No other mode change alters R8 to R12.
- R4: A status write whose mode field equals the current mode only replaces the status word. No register and no saved-status word changes.
- R5: `excCode` selects the exception: 0 reset, 1 undefined, 2 software interrupt, 3 prefetch abort, 4 data abort, 5 interrupt, 6 fast interrupt. The target modes are supervisor for codes 0 and 2, undefined for code 1, abort for codes 3 and 4, interrupt for code 5 and fast interrupt for code 6.
- R6: On entry, existing mask bits are kept and further mask bits are set by exception. Reset sets A, I and F. Undefined and software interrupt set I. Both aborts and interrupt set A and I. Fast interrupt sets A, I and F.
- R7: On entry, the new saved-status word holds the complete status word from before entry. The mode field is replaced and the T bit (bit 5) is cleared.
- R8: On entry, R14 receives the old PC plus an offset: 0 for reset, undefined and software interrupt, 4 for prefetch abort, interrupt and fast interrupt, and 8 for data abort. PC receives the vector offset: 0x00, 0x04, 0x08, 0x0C, 0x10, 0x18 or 0x1C in code order.
- R9: When `highVec` is 1 during entry, the vector offset is added to base 0xFFFF0000 instead of zero.
- R10: An exception code of 7, or a status write with a mode field outside the R2 encodings, is dropped. In that case `modeErr` is 1 for exactly the following cycle.
- R11: When requests coincide in one cycle, only one acts. An exception request wins over a status write, and a status write wins over a register write.
- R12: Every accepted request is visible on the outputs one clock edge after it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| excValid | input | 1 | Exception request strobe |
| excCode | input | 3 | Exception kind (R5) |
| highVec | input | 1 | Use high vector base |
| statusWrEn | input | 1 | Status-word write strobe |
| statusWrData | input | 32 | New status word |
| regWrEn | input | 1 | Register write strobe |
| regWrAddr | input | 4 | Register write index |
| regWrData | input | 32 | Register write value |
| regRdAddr | input | 4 | Register read index |
| regRdData | output | 32 | Current-view register value |
| cpsrOut | output | 32 | Current status word |
| spsrOut | output | 32 | Current saved-status word |
| modeErr | output | 1 | Dropped-request pulse |

## Verification
Every result of this block, including register contents, both status words and the error pulse, is due exactly one rising edge after its request. The bench drives each request just after a falling edge and waits for one rising edge. It samples at the next falling edge, where the read port is combinational from registered state. The error pulse is checked both at that sample point and one cycle later, which confirms that it lasts a single cycle. Each check targets a value that only the tested request could have produced, such as a restored bank copy or an offset link value.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
  localparam int XLEN    = 32;
  localparam int NREG    = 16;
  localparam int RIDX    = $clog2(NREG);
  localparam int NFIQ    = 5;
  localparam int FIQ_LO  = 8;
  localparam int NBANK   = 6;
  localparam int BIDX    = $clog2(NBANK);
  localparam int BIT_T   = 5;
  localparam int BIT_F   = 6;
  localparam int BIT_I   = 7;
  localparam int BIT_A   = 8;
  localparam logic [XLEN-1:0] HIGH_BASE  = 32'hFFFF_0000;
  localparam logic [XLEN-1:0] RESET_STAT = 32'h0000_01D3;

  localparam logic [4:0] MODE_USR = 5'h10;
  localparam logic [4:0] MODE_FIQ = 5'h11;
  localparam logic [4:0] MODE_IRQ = 5'h12;
  localparam logic [4:0] MODE_SVC = 5'h13;
  localparam logic [4:0] MODE_ABT = 5'h17;
  localparam logic [4:0] MODE_UND = 5'h1B;
  localparam logic [4:0] MODE_SYS = 5'h1F;

  typedef enum logic [2:0] {
    EXC_RESET, EXC_UND, EXC_SWI, EXC_PABT, EXC_DABT, EXC_IRQ, EXC_FIQ, EXC_NONE
  } excT;

  typedef struct packed {
    logic            entry;
    logic            statusWr;
    logic            regWr;
    logic            swap;
    logic            err;
    logic [4:0]      oldMode;
    logic [4:0]      newMode;
    logic [XLEN-1:0] newStat;
    logic [XLEN-1:0] linkVal;
    logic [XLEN-1:0] vecAddr;
  } strobeT;

  function automatic logic modeOk(input logic [4:0] m);
    return (m == MODE_USR) || (m == MODE_FIQ) || (m == MODE_IRQ) || (m == MODE_SVC) ||
           (m == MODE_ABT) || (m == MODE_UND) || (m == MODE_SYS);
  endfunction

  function automatic logic [BIDX-1:0] bankOf(input logic [4:0] m);
    case (m)
      MODE_SVC: return BIDX'(1);
      MODE_ABT: return BIDX'(2);
      MODE_UND: return BIDX'(3);
      MODE_IRQ: return BIDX'(4);
      MODE_FIQ: return BIDX'(5);
      default:  return BIDX'(0);
    endcase
  endfunction
endpackage

// File: rtl/exc_seq_ctrl.sv
module exc_seq_ctrl
  import exc_seq_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            excValid,
  input  logic [2:0]      excCode,
  input  logic            highVec,
  input  logic            statusWrEn,
  input  logic [XLEN-1:0] statusWrData,
  input  logic            regWrEn,
  input  logic [XLEN-1:0] curStat,
  input  logic [XLEN-1:0] curPc,
  output strobeT          stb
);
  excT             code;
  logic [4:0]      curMode;
  logic [4:0]      tgtMode;
  logic [XLEN-1:0] maskBits;
  logic [XLEN-1:0] linkOff;
  logic [XLEN-1:0] vecOff;
  logic            codeOk;

  assign code    = excT'(excCode);
  assign curMode = curStat[4:0];

  always_comb begin
    tgtMode  = MODE_SVC;
    maskBits = '0;
    linkOff  = '0;
    vecOff   = '0;
    codeOk   = 1'b1;
    case (code)
      EXC_RESET: begin
        maskBits = (XLEN'(1) << BIT_A) | (XLEN'(1) << BIT_I) | (XLEN'(1) << BIT_F);
      end
      EXC_UND: begin
        tgtMode = MODE_UND; maskBits = XLEN'(1) << BIT_I; vecOff = 32'h04;
      end
      EXC_SWI: begin
        maskBits = XLEN'(1) << BIT_I; vecOff = 32'h08;
      end
      EXC_PABT: begin
        tgtMode = MODE_ABT; maskBits = (XLEN'(1) << BIT_A) | (XLEN'(1) << BIT_I);
        linkOff = 32'h4; vecOff = 32'h0C;
      end
      EXC_DABT: begin
        tgtMode = MODE_ABT; maskBits = (XLEN'(1) << BIT_A) | (XLEN'(1) << BIT_I);
        linkOff = 32'h8; vecOff = 32'h10;
      end
      EXC_IRQ: begin
        tgtMode = MODE_IRQ; maskBits = (XLEN'(1) << BIT_A) | (XLEN'(1) << BIT_I);
        linkOff = 32'h4; vecOff = 32'h18;
      end
      EXC_FIQ: begin
        tgtMode = MODE_FIQ;
        maskBits = (XLEN'(1) << BIT_A) | (XLEN'(1) << BIT_I) | (XLEN'(1) << BIT_F);
        linkOff = 32'h4; vecOff = 32'h1C;
      end
      default: codeOk = 1'b0;
    endcase
  end

  always_comb begin
    stb = '0;
    stb.oldMode = curMode;
    stb.newMode = curMode;
    if (excValid) begin
      if (codeOk) begin
        stb.entry   = 1'b1;
        stb.newMode = tgtMode;
        stb.swap    = (tgtMode != curMode);
        stb.newStat = (curStat & ~XLEN'(6'h3F)) | XLEN'(tgtMode) | maskBits;
        stb.linkVal = curPc + linkOff;
        stb.vecAddr = (highVec ? HIGH_BASE : '0) | vecOff;
      end else begin
        stb.err = 1'b1;
      end
    end else if (statusWrEn) begin
      if (modeOk(statusWrData[4:0])) begin
        stb.statusWr = 1'b1;
        stb.newMode  = statusWrData[4:0];
        stb.swap     = (statusWrData[4:0] != curMode);
        stb.newStat  = statusWrData;
      end else begin
        stb.err = 1'b1;
      end
    end else if (regWrEn) begin
      stb.regWr = 1'b1;
    end
  end

  // R11
  one_action_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.entry, stb.statusWr, stb.regWr, stb.err}));

  // R10
  err_no_swap_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.err |-> !stb.swap);
endmodule

// File: rtl/exc_seq_dp.sv
module exc_seq_dp
  import exc_seq_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  strobeT          stb,
  input  logic [RIDX-1:0] regWrAddr,
  input  logic [XLEN-1:0] regWrData,
  input  logic [RIDX-1:0] regRdAddr,
  output logic [XLEN-1:0] regRdData,
  output logic [XLEN-1:0] statQ,
  output logic [XLEN-1:0] spsrQ,
  output logic [XLEN-1:0] curPc,
  output logic            errQ
);
  logic [XLEN-1:0] regs     [NREG];
  logic [XLEN-1:0] bankR13  [NBANK];
  logic [XLEN-1:0] bankR14  [NBANK];
  logic [XLEN-1:0] bankSpsr [NBANK];
  logic [XLEN-1:0] fiqShadow[NFIQ];
  logic [XLEN-1:0] usrShadow[NFIQ];
  logic [BIDX-1:0] oldBank, newBank;

  assign oldBank   = bankOf(stb.oldMode);
  assign newBank   = bankOf(stb.newMode);
  assign regRdData = regs[regRdAddr];
  assign curPc     = regs[NREG-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
      for (int b = 0; b < NBANK; b++) begin
        bankR13[b] <= '0; bankR14[b] <= '0; bankSpsr[b] <= '0;
      end
      for (int k = 0; k < NFIQ; k++) begin
        fiqShadow[k] <= '0; usrShadow[k] <= '0;
      end
      statQ <= RESET_STAT;
      spsrQ <= '0;
      errQ  <= 1'b0;
    end else begin
      errQ <= stb.err;
      if (stb.swap) begin
        if (oldBank != newBank) begin
          bankR13[oldBank]  <= regs[13];
          bankR14[oldBank]  <= regs[14];
          bankSpsr[oldBank] <= spsrQ;
          regs[13]          <= bankR13[newBank];
          regs[14]          <= bankR14[newBank];
          spsrQ             <= bankSpsr[newBank];
        end
        if (stb.oldMode == MODE_FIQ) begin
          for (int k = 0; k < NFIQ; k++) begin
            fiqShadow[k]     <= regs[FIQ_LO+k];
            regs[FIQ_LO+k]   <= usrShadow[k];
          end
        end else if (stb.newMode == MODE_FIQ) begin
          for (int k = 0; k < NFIQ; k++) begin
            usrShadow[k]     <= regs[FIQ_LO+k];
            regs[FIQ_LO+k]   <= fiqShadow[k];
          end
        end
      end
      if (stb.entry) begin
        spsrQ       <= statQ;
        regs[14]    <= stb.linkVal;
        regs[NREG-1] <= stb.vecAddr;
        statQ       <= stb.newStat;
      end
      if (stb.statusWr) statQ <= stb.newStat;
      if (stb.regWr) regs[regWrAddr] <= regWrData;
    end
  end

  // R6
  fiq_masks_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.entry && stb.newMode == MODE_FIQ) |=> (statQ[BIT_F] && statQ[BIT_I] && statQ[BIT_A]));

  // R7
  thumb_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.entry |=> (!statQ[BIT_T] && spsrQ == $past(statQ)));

  // R10
  err_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.err |=> (errQ && $stable(statQ) && $stable(spsrQ)));

  // R3
  fiq_untouched_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.swap && stb.oldMode != MODE_FIQ && stb.newMode != MODE_FIQ) |=> $stable(regs[FIQ_LO]));

  // R2
  mode_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeOk(statQ[4:0]));
endmodule

// File: rtl/exc_seq_top.sv
module exc_seq_top
  import exc_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        excValid,
  input  logic [2:0]  excCode,
  input  logic        highVec,
  input  logic        statusWrEn,
  input  logic [31:0] statusWrData,
  input  logic        regWrEn,
  input  logic [3:0]  regWrAddr,
  input  logic [31:0] regWrData,
  input  logic [3:0]  regRdAddr,
  output logic [31:0] regRdData,
  output logic [31:0] cpsrOut,
  output logic [31:0] spsrOut,
  output logic        modeErr
);
  strobeT          stb;
  logic [XLEN-1:0] curPc;

  exc_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .excValid(excValid), .excCode(excCode), .highVec(highVec),
    .statusWrEn(statusWrEn), .statusWrData(statusWrData), .regWrEn(regWrEn),
    .curStat(cpsrOut), .curPc(curPc), .stb(stb)
  );

  exc_seq_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .regWrAddr(regWrAddr), .regWrData(regWrData),
    .regRdAddr(regRdAddr), .regRdData(regRdData), .statQ(cpsrOut), .spsrQ(spsrOut),
    .curPc(curPc), .errQ(modeErr)
  );
endmodule

// File: tb/exc_seq_top_tb.sv
`timescale 1ns/1ps
module exc_seq_top_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        excValid = 1'b0;
  logic [2:0]  excCode = '0;
  logic        highVec = 1'b0;
  logic        statusWrEn = 1'b0;
  logic [31:0] statusWrData = '0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regWrAddr = '0;
  logic [31:0] regWrData = '0;
  logic [3:0]  regRdAddr = '0;
  logic [31:0] regRdData, cpsrOut, spsrOut;
  logic        modeErr;
  int nChecks = 0;
  int nFail = 0;

  exc_seq_top u_dut (.*);

  always #2 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkReg(input string tag, input int idx, input logic [31:0] exp);
    regRdAddr = 4'(idx);
    #0.5;
    check(tag, regRdData, exp);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    excValid = 0; statusWrEn = 0; regWrEn = 0; highVec = 0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0;
    step();
    rstN = 1;
  endtask

  task automatic wrReg(input int idx, input logic [31:0] d);
    regWrEn = 1; regWrAddr = 4'(idx); regWrData = d;
    step();
  endtask

  task automatic wrStat(input logic [31:0] d);
    statusWrEn = 1; statusWrData = d;
    step();
  endtask

  task automatic takeExc(input logic [2:0] c, input logic hv);
    excValid = 1; excCode = c; highVec = hv;
    step();
  endtask

  task automatic testReset();
    doReset();
    check("R1 cpsr", cpsrOut, 32'h1D3);
    check("R1 spsr", spsrOut, 32'h0);
    checkReg("R1 r13", 13, 0);
    checkReg("R1 pc", 15, 0);
  endtask

  task automatic testFiqBanking();
    doReset();
    for (int i = 8; i <= 12; i++) wrReg(i, 32'h80 + i);
    wrReg(13, 32'hA13); wrReg(14, 32'hA14); wrReg(15, 32'h200);
    wrStat(32'h10);
    check("R12 cpsr usr", cpsrOut, 32'h10);
    checkReg("R2 usr r13", 13, 0);
    checkReg("R3 r8 kept", 8, 32'h88);
    wrReg(13, 32'hB13);
    takeExc(3'd6, 0);
    check("R5 R6 fiq cpsr", cpsrOut, 32'h1D1);
    check("R7 fiq spsr", spsrOut, 32'h10);
    checkReg("R8 fiq lr", 14, 32'h204);
    checkReg("R8 fiq vec", 15, 32'h1C);
    checkReg("R3 fiq r8", 8, 0);
    checkReg("R2 fiq r13", 13, 0);
    wrReg(8, 32'hF8);
    wrStat(32'h10);
    checkReg("R3 back r8", 8, 32'h88);
    checkReg("R3 back r12", 12, 32'h8C);
    checkReg("R2 usr r13 back", 13, 32'hB13);
    wrStat(32'h13);
    checkReg("R2 svc r13", 13, 32'hA13);
    checkReg("R2 svc r14", 14, 32'hA14);
    checkReg("R3 svc r8", 8, 32'h88);
    wrStat(32'h11);
    checkReg("R3 fiq shadow", 8, 32'hF8);
  endtask

  task automatic testIrqHigh();
    doReset();
    wrReg(15, 32'h300);
    wrStat(32'h1F);
    wrReg(13, 32'h513);
    takeExc(3'd5, 1);
    check("R5 R6 irq cpsr", cpsrOut, 32'h192);
    check("R7 irq spsr", spsrOut, 32'h1F);
    checkReg("R8 irq lr", 14, 32'h304);
    checkReg("R9 high vec", 15, 32'hFFFF0018);
    wrStat(32'h10);
    checkReg("R2 usr sys shared", 13, 32'h513);
  endtask

  task automatic testAborts();
    doReset();
    wrReg(15, 32'h400);
    wrStat(32'h30);
    takeExc(3'd4, 0);
    check("R7 dabt cpsr T cleared", cpsrOut, 32'h197);
    check("R7 dabt spsr", spsrOut, 32'h30);
    checkReg("R8 dabt lr", 14, 32'h408);
    checkReg("R8 dabt vec", 15, 32'h10);
    doReset();
    wrReg(15, 32'h500);
    takeExc(3'd3, 0);
    check("R6 pabt cpsr", cpsrOut, 32'h1D7);
    check("R7 pabt spsr", spsrOut, 32'h1D3);
    checkReg("R8 pabt lr", 14, 32'h504);
    checkReg("R8 pabt vec", 15, 32'h0C);
  endtask

  task automatic testUndSwiReset();
    doReset();
    wrReg(15, 32'h600);
    wrStat(32'h10);
    takeExc(3'd1, 0);
    check("R5 R6 und cpsr", cpsrOut, 32'h9B);
    checkReg("R8 und lr", 14, 32'h600);
    checkReg("R8 und vec", 15, 32'h04);
    wrStat(32'h10);
    takeExc(3'd2, 0);
    check("R5 R6 swi cpsr", cpsrOut, 32'h93);
    check("R7 swi spsr", spsrOut, 32'h10);
    checkReg("R8 swi lr", 14, 32'h04);
    checkReg("R8 swi vec", 15, 32'h08);
    takeExc(3'd0, 0);
    check("R6 reset exc cpsr", cpsrOut, 32'h1D3);
    check("R7 reset exc spsr", spsrOut, 32'h93);
    checkReg("R8 reset exc lr", 14, 32'h08);
    checkReg("R8 reset exc vec", 15, 32'h00);
  endtask

  task automatic testSameMode();
    doReset();
    wrReg(13, 32'h77);
    wrStat(32'hF00001D3);
    check("R4 cpsr flags", cpsrOut, 32'hF00001D3);
    checkReg("R4 r13 kept", 13, 32'h77);
    check("R4 spsr kept", spsrOut, 32'h0);
  endtask

  task automatic testErrors();
    doReset();
    wrStat(32'h15);
    check("R10 err pulse", {31'b0, modeErr}, 1);
    check("R10 cpsr kept", cpsrOut, 32'h1D3);
    step();
    check("R10 err one cycle", {31'b0, modeErr}, 0);
    takeExc(3'd7, 0);
    check("R10 bad code err", {31'b0, modeErr}, 1);
    check("R10 bad code cpsr", cpsrOut, 32'h1D3);
    checkReg("R10 bad code pc", 15, 0);
  endtask

  task automatic testPriority();
    doReset();
    excValid = 1; excCode = 3'd5;
    statusWrEn = 1; statusWrData = 32'h10;
    regWrEn = 1; regWrAddr = 4'd13; regWrData = 32'h99;
    step();
    check("R11 exc wins", cpsrOut, 32'h1D2);
    checkReg("R11 reg write dropped", 13, 0);
    statusWrEn = 1; statusWrData = 32'h13;
    regWrEn = 1; regWrAddr = 4'd13; regWrData = 32'h55;
    step();
    check("R11 status wins", cpsrOut, 32'h13);
    checkReg("R11 svc r13 untouched", 13, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    testReset();
    testFiqBanking();
    testIrqHigh();
    testAborts();
    testUndSwiReset();
    testSameMode();
    testErrors();
    testPriority();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule